// File: doc/BRIEF.md
# Single-Channel Memory Copy DMA Engine

The block moves data from one place in memory to another without processor involvement. Software programs a source base, a destination base and a control word through a small register port. It then arms the channel. A request input, already synchronised to the clock by a neighbouring block, starts the work. The engine answers with an acknowledge. It then runs atomic operations on a simple synchronous memory master port. Each operation reads one item from the current source into a holding register and writes that item to the current destination.

An atomic operation moves one item (unit mode) or four items (burst mode). An item is 8, 16 or 32 bits wide. Each side's address either steps by the item size after every item or stays fixed. In single service mode a request buys exactly one atomic operation. In whole service mode one request runs operations until the count is exhausted. When the count reaches zero the channel disarms itself. If enabled, it also gives a one-cycle completion interrupt.

Memory port timing: a read issued in one cycle returns its data on `mem_rdata` in the following cycle. Data is right-justified; for a write, byte k of the item sits in `mem_wdata[8k+7:8k]` at address `mem_addr+k`.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset `ack`, `irq`, `mem_rd` and `mem_wr` are low, and the status word (read index 2) shows busy bit 31 low and count 0.
- R2: When the channel is armed, idle and `req` is high with no configuration write in that cycle, `ack` is high in the next cycle. On the first acceptance after arming, the current count is loaded from the programmed count one cycle after `ack` rises.
- R3: Each item is read at the current source address (`mem_rd`), captured in the cycle after, and written unchanged to the current destination address (`mem_wr`) two cycles after the read.
- R4: An atomic operation is one read/write item pair with control bit 20 clear (unit) and four pairs with bit 20 set (burst).
- R5: Control bits [17:16] select the item size: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. `mem_size` carries this code during accesses, and bits of `mem_wdata` above the item are zero.
- R6: The current count drops by one after each atomic operation. With control bit 21 clear (single), `ack` falls after each operation, and a new request is needed for the next. With bit 21 set (whole), `ack` stays high until the count reaches zero.
- R7: When the count reaches zero the channel disarms. If control bit 22 is set, `irq` is high for exactly one cycle; if it is clear, `irq` stays low.
- R8: With control bit 18 (source) or bit 19 (destination) clear, that address advances by the item size in bytes (1, 2 or 4) after every item, burst items included. With the bit set, the address stays fixed.
- R9: Writes at index 0 and 1 set the source and destination bases. Reads at index 0 and 1 return the current source and destination addresses. Read index 2 returns the current count in its low bits and busy (channel armed or active) in bit 31.
- R10: A write at index 2 with arm bit 23 set copies the bases into the current addresses. It arms the channel only if the count field (bits [CW-1:0]) is non-zero. A zero count leaves the channel idle, with no acknowledge and no interrupt.
- R11: Configuration writes made while `ack` is high are ignored. The running transfer completes with its original parameters, and the base registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register index: 0 source, 1 destination, 2 control/status |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Status read data for `cfg_addr` |
| req | input | 1 | Synchronised transfer request |
| ack | output | 1 | Request acknowledge, high while the channel owns the memory port |
| irq | output | 1 | One-cycle completion interrupt |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Item size code of the access |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
Two events can fall in the same cycle: the last write of the final atomic operation and a request that is still held high. The channel must take the completion path, not start another operation. The bench holds `req` high through every transfer, in both service modes. It then judges the result by three observations: the number of `ack` rises (one per operation in single mode, one in whole mode), a single `irq` pulse, and the busy bit being clear afterwards. The second overlap is a configuration write landing in the middle of a whole-service transfer. For this case the bench checks the number of writes, the final source address and a later readback of the base value.

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int AW = 32,
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req,
  output logic          ack,
  output logic          irq,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int F_SIZE  = 16;
  localparam int F_SFIX  = 18;
  localparam int F_DFIX  = 19;
  localparam int F_BURST = 20;
  localparam int F_WHOLE = 21;
  localparam int F_IRQEN = 22;
  localparam int F_ARM   = 23;
  localparam int BURST_LEN = 4;
  localparam int BW = $clog2(BURST_LEN);

  typedef enum logic [1:0] {M_IDLE, M_LOAD, M_XFER} mst_t;
  typedef enum logic [1:0] {A_RD, A_CAP, A_WR} atom_t;

  mst_t            mst;
  atom_t           atom;
  logic [AW-1:0]   src_base, dst_base, cur_src, cur_dst, step;
  logic [CW-1:0]   cnt_prog, cur_cnt;
  logic [1:0]      size_q;
  logic            src_fix, dst_fix, burst_q, whole_q, irq_en_q, armed, fresh;
  logic [31:0]     hold, mask;
  logic [BW-1:0]   beat;
  logic            last_beat, cfg_ok, start;

  assign cfg_ok    = cfg_we && (mst == M_IDLE);
  assign start     = (mst == M_IDLE) && req && armed && !cfg_we;
  assign step      = (size_q == 2'd0) ? AW'(1) : (size_q == 2'd1) ? AW'(2) : AW'(4);
  assign mask      = (size_q == 2'd0) ? 32'h0000_00FF :
                     (size_q == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign last_beat = !burst_q || (beat == BW'(BURST_LEN - 1));

  assign ack       = (mst != M_IDLE);
  assign mem_rd    = (mst == M_XFER) && (atom == A_RD);
  assign mem_wr    = (mst == M_XFER) && (atom == A_WR);
  assign mem_addr  = mem_wr ? cur_dst : cur_src;
  assign mem_size  = size_q;
  assign mem_wdata = hold;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0:    cfg_rdata = 32'(cur_src);
      2'd1:    cfg_rdata = 32'(cur_dst);
      2'd2:    begin
                 cfg_rdata = 32'(cur_cnt);
                 cfg_rdata[31] = armed || ack;
               end
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= M_IDLE;  atom <= A_RD;  beat <= '0;
      src_base <= '0; dst_base <= '0; cur_src <= '0; cur_dst <= '0;
      cnt_prog <= '0; cur_cnt <= '0; size_q <= '0; hold <= '0;
      src_fix <= 1'b0; dst_fix <= 1'b0; burst_q <= 1'b0; whole_q <= 1'b0;
      irq_en_q <= 1'b0; armed <= 1'b0; fresh <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cfg_ok) begin
        case (cfg_addr)
          2'd0: src_base <= cfg_wdata[AW-1:0];
          2'd1: dst_base <= cfg_wdata[AW-1:0];
          2'd2: begin
            cnt_prog <= cfg_wdata[CW-1:0];
            size_q   <= cfg_wdata[F_SIZE +: 2];
            src_fix  <= cfg_wdata[F_SFIX];
            dst_fix  <= cfg_wdata[F_DFIX];
            burst_q  <= cfg_wdata[F_BURST];
            whole_q  <= cfg_wdata[F_WHOLE];
            irq_en_q <= cfg_wdata[F_IRQEN];
            armed    <= cfg_wdata[F_ARM] && (cfg_wdata[CW-1:0] != '0);
            fresh    <= cfg_wdata[F_ARM] && (cfg_wdata[CW-1:0] != '0);
            if (cfg_wdata[F_ARM]) begin
              cur_src <= src_base;
              cur_dst <= dst_base;
            end
          end
          default: ;
        endcase
      end
      case (mst)
        M_IDLE: if (start) mst <= M_LOAD;
        M_LOAD: begin
          if (fresh) begin
            cur_cnt <= cnt_prog;
            fresh   <= 1'b0;
          end
          mst  <= M_XFER;
          atom <= A_RD;
          beat <= '0;
        end
        M_XFER: begin
          case (atom)
            A_RD:  atom <= A_CAP;
            A_CAP: begin
              hold <= mem_rdata & mask;
              atom <= A_WR;
            end
            default: begin
              if (!src_fix) cur_src <= cur_src + step;
              if (!dst_fix) cur_dst <= cur_dst + step;
              atom <= A_RD;
              beat <= beat + BW'(1);
              if (last_beat) begin
                beat    <= '0;
                cur_cnt <= cur_cnt - CW'(1);
                if (cur_cnt == CW'(1)) begin
                  armed <= 1'b0;
                  irq   <= irq_en_q;
                  mst   <= M_IDLE;
                end else if (!whole_q) begin
                  mst <= M_IDLE;
                end
              end
            end
          endcase
        end
        default: mst <= M_IDLE;
      endcase
    end
  end

  assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req));
  assert_wr_follows_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));
  assert_burst_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && burst_q && !last_beat) |=> mem_rd);
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && last_beat) |=> (cur_cnt == $past(cur_cnt) - CW'(1)));
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cur_cnt == '0 && !armed && $past(irq_en_q)));
  assert_fixed_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && dst_fix) |=> (cur_dst == $past(cur_dst)));
  assert_zero_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && cfg_addr == 2'd2 && cfg_wdata[CW-1:0] == '0) |=> !armed);
  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ack) |=> (src_base == $past(src_base) && dst_base == $past(dst_base)
                         && cnt_prog == $past(cnt_prog)));
endmodule

// File: tb/dma_copy_engine_tb.sv
module dma_copy_engine_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, req = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        ack, irq, mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_size;

  int errors = 0, checks = 0, cycles = 0;

  dma_copy_engine #(.AW(32), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .ack(ack), .irq(irq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #2 clk = ~clk;

  // vector: src[29:22] dst[21:14] cnt[13:6] size[5:4] sfix[3] dfix[2] burst[1] whole[0]
  localparam logic [29:0] VEC [6] = '{
    {8'h10, 8'h80, 8'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h04, 8'h90, 8'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h20, 8'hA0, 8'd2, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h08, 8'hC4, 8'd4, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h30, 8'hE0, 8'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h40, 8'h84, 8'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic init_mem = 1'b0, clr_mon = 1'b0;
  int n_ack = 0, n_irq = 0, n_wr = 0;
  logic ack_prev = 1'b0, wide_bad = 1'b0;
  logic [1:0] last_size = '0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [31:0] ctl(int cnt, int sz, bit sf, bit df, bit b, bit w, bit ie, bit arm);
    return {8'd0, arm, ie, w, b, df, sf, 2'(sz), 16'(cnt)};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (init_mem) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else begin
      if (mem_rd)
        mem_rdata <= {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                      mem[8'(mem_addr + 1)], mem[8'(mem_addr[7:0])]};
      if (mem_wr)
        for (int k = 0; k < 4; k++)
          if (k < (1 << ((mem_size == 2'd3) ? 2 : mem_size)))
            mem[8'(mem_addr + k)] <= mem_wdata[8*k +: 8];
    end
  end

  always @(negedge clk) begin
    if (clr_mon) begin
      n_ack = 0; n_irq = 0; n_wr = 0; wide_bad = 1'b0; ack_prev = ack;
    end else begin
      if (ack && !ack_prev) n_ack++;
      ack_prev = ack;
      if (irq) n_irq++;
      if (mem_wr) begin
        n_wr++;
        last_size = mem_size;
        if (mem_size == 2'd0 && mem_wdata[31:8] != '0) wide_bad = 1'b1;
        if (mem_size == 2'd1 && mem_wdata[31:16] != '0) wide_bad = 1'b1;
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    cfg_addr = a; #1 v = cfg_rdata;
  endtask

  task automatic prep();
    @(negedge clk); init_mem = 1'b1; clr_mon = 1'b1;
    @(negedge clk); init_mem = 1'b0; clr_mon = 1'b0;
    for (int i = 0; i < 256; i++) expm[i] = pat(i);
  endtask

  task automatic wait_irq(int limit);
    int t = 0;
    while (n_irq == 0 && t < limit) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ack && !irq && !mem_rd && !mem_wr, "R1 idle outputs", {ack, irq, mem_rd, mem_wr}, 0);
    rd(2, v); chk(v == 0, "R1 status after reset", v, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[n]) begin
      logic [7:0] s, d, cnt; logic [1:0] sz; bit sf, df, b, w;
      int nb, items;
      logic [7:0] ps, pd;
      {s, d, cnt, sz, sf, df, b, w} = VEC[n];
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      items = cnt * (b ? 4 : 1);
      prep();
      ps = s; pd = d;
      for (int it = 0; it < items; it++) begin
        for (int k = 0; k < nb; k++) expm[8'(pd + k)] = pat(8'(ps + k));
        if (!sf) ps = 8'(ps + nb);
        if (!df) pd = 8'(pd + nb);
      end
      wr(0, 32'(s)); wr(1, 32'(d));
      wr(2, ctl(cnt, sz, sf, df, b, w, 1'b1, 1'b1));
      req = 1'b1;
      wait_irq(3000);
      req = 1'b0;
      begin
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
        chk(bad == 0, $sformatf("R3 R8 copy result vec%0d", n), bad, 0);
      end
      chk(n_wr == items, $sformatf("R4 item writes vec%0d", n), n_wr, items);
      chk(last_size == sz && !wide_bad, $sformatf("R5 size and justification vec%0d", n),
          {wide_bad, last_size}, sz);
      chk(n_ack == (w ? 1 : cnt), $sformatf("R6 ack count vec%0d", n), n_ack, w ? 1 : cnt);
      chk(n_irq == 1, $sformatf("R7 one irq cycle vec%0d", n), n_irq, 1);
      rd(0, v); chk(v == 32'(s) + (sf ? 0 : nb * items), $sformatf("R8 R9 final src vec%0d", n),
                    v, 32'(s) + (sf ? 0 : nb * items));
      rd(1, v); chk(v == 32'(d) + (df ? 0 : nb * items), $sformatf("R8 R9 final dst vec%0d", n),
                    v, 32'(d) + (df ? 0 : nb * items));
      rd(2, v); chk(v == 0, $sformatf("R6 R9 status idle vec%0d", n), v, 0);
    end

    // R2 acknowledge timing and count load, R6 single service waits for a new request
    prep();
    wr(0, 32'h0); wr(1, 32'h80); wr(2, ctl(2, 2, 0, 0, 0, 0, 1, 1));
    req = 1'b1;
    @(negedge clk); chk(ack == 1'b1, "R2 ack one cycle after req", ack, 1);
    @(negedge clk); req = 1'b0; rd(2, v);
    chk(v == 32'h8000_0002, "R2 count loaded", v, 32'h8000_0002);
    repeat (20) @(negedge clk);
    rd(2, v); chk(v == 32'h8000_0001 && n_ack == 1 && n_wr == 1, "R6 single op then wait",
                  v, 32'h8000_0001);
    req = 1'b1; wait_irq(200); req = 1'b0;
    rd(2, v); chk(v == 0 && n_irq == 1, "R6 single completes on next req", v, 0);

    // R10 zero count rejected
    prep();
    wr(2, ctl(0, 0, 0, 0, 0, 1, 1, 1));
    req = 1'b1; repeat (30) @(negedge clk); req = 1'b0;
    rd(2, v); chk(v == 0 && n_ack == 0 && n_irq == 0, "R10 zero count stays idle", n_ack, 0);

    // R7 interrupt disabled
    prep();
    wr(0, 32'h0); wr(1, 32'h80); wr(2, ctl(2, 0, 0, 0, 0, 1, 0, 1));
    req = 1'b1; repeat (60) @(negedge clk); req = 1'b0;
    rd(2, v); chk(v == 0 && n_irq == 0 && n_wr == 2, "R7 no irq when disabled", n_irq, 0);

    // R11 writes ignored while busy
    prep();
    wr(0, 32'h10); wr(1, 32'h80); wr(2, ctl(6, 0, 0, 0, 0, 1, 1, 1));
    req = 1'b1;
    repeat (5) @(negedge clk);
    wr(0, 32'hF0); wr(2, ctl(1, 0, 0, 0, 0, 1, 1, 1));
    wait_irq(300); req = 1'b0;
    chk(n_wr == 6 && n_irq == 1, "R11 transfer keeps parameters", n_wr, 6);
    rd(0, v); chk(v == 32'h16, "R11 final src unaffected", v, 32'h16);
    wr(2, ctl(1, 0, 0, 0, 0, 1, 1, 1));
    rd(0, v); chk(v == 32'h10, "R11 base kept after busy write", v, 32'h10);
    wr(2, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule